// File: doc/BRIEF.md
# DSI Bridge PLL Configuration Word Calculator

This block turns two operating figures, the wanted bit rate on one serial data lane (in kbps) and the frequency of the reference clock that feeds the bridge PLL (in kHz), into the 16-bit word that programs that PLL. It works sequentially. First a short search picks the input predivider. Then one shared shift-subtract divider computes, in turn, the rounded-up feedback multiplier, the output frequency that multiplier really gives, the frequency that the packed word decodes back to, and the divider for the low-power escape clock.

A host raises `start` for one cycle with both operands valid. `busy` stays high while the calculation runs, and `done` pulses for one cycle when the three results appear at the outputs. The results then hold until the next calculation completes. A `start` that arrives while `busy` is high has no effect.

Top module: `pll_word_calc`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `pll_word`, `pll_freq` and `lp_field` are all 0.
- R2: The predivider is floor(ref_khz / 5000), raised to at least 1 and limited to at most 31. It is placed in `pll_word[12:8]`, and `pll_word[13]` is always 0.
- R3: The multiplier is ceil(target_kbps × predivider / ref_khz). Its low 8 bits are placed in `pll_word[7:0]`.
- R4: The achieved rate is floor(ref_khz × multiplier / predivider), using the full multiplier. `pll_word[15:14]` holds code 3 if that rate is at least 501000, code 2 if it is at least 251000, code 1 if it is at least 126000, and code 0 otherwise.
- R5: `pll_freq` = floor(ref_khz × m / p), where m and p are the multiplier and predivider fields of `pll_word`, and a field equal to zero counts as 1.
- R6: `lp_field` = (ceil(pll_freq / 80000) − 1), keeping only the low 6 bits.
- R7: `done` is high for exactly one cycle per calculation. `pll_word`, `pll_freq` and `lp_field` change only in the cycle in which `done` is high.
- R8: `start` sampled while idle makes `busy` high in the next cycle. `start` sampled while `busy` is high is ignored, so the results belong to the operands captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request; operands are captured when idle |
| target_kbps | input | 32 | Wanted per-lane bit rate in kbps |
| ref_khz | input | 32 | PLL reference frequency in kHz, nonzero |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when the results update |
| pll_word | output | 16 | Packed range code, predivider and multiplier |
| pll_freq | output | 40 | Frequency decoded from `pll_word`, in kbps |
| lp_field | output | 6 | Low-power clock divider field |

## Verification
The range code is hard to reach at its exact boundaries. Random operands almost never make the achieved rate equal 126000, 251000 or 501000, because the rate comes out of a ceiling and then a floor division. The bench therefore uses a 1000 kHz reference, which makes the predivider 1 and the achieved rate a whole multiple of 1000, and sets the target exactly on each threshold and just below it. Two other cases also get directed operands: a multiplier of exactly 256, whose zero field must decode as 1, and a decoded frequency large enough to wrap the 6-bit low-power field.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEARCH,
      ST_MUL,
      ST_ACH,
      ST_DEC,
      ST_LP
   } calc_st_t;

   localparam int unsigned WORD_W  = 16;
   localparam int unsigned RANGE_W = 2;
   localparam int unsigned RANGE_N = 3;

   // ascending rate thresholds (kbps); the number of thresholds met is the code
   localparam longint unsigned RANGE_TH [RANGE_N] = '{64'd126000, 64'd251000, 64'd501000};

endpackage

// File: rtl/pllcfg_presearch.sv
module pllcfg_presearch #(
   parameter int unsigned W        = 32,
   parameter int unsigned PD_W     = 5,
   parameter int unsigned STEP_KHZ = 5000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [W-1:0]    ref_khz,
   output logic            fin,
   output logic [PD_W-1:0] pdiv
);
   localparam int unsigned LW     = W + 1;
   localparam int unsigned PD_MAX = (1 << PD_W) - 1;

   logic [LW-1:0] lim_q;
   logic          run_q;
   logic          step_c;

   // advance while the reference still covers STEP_KHZ per (pdiv+1)
   always_comb begin
      step_c = (pdiv != PD_W'(PD_MAX)) && ({1'b0, ref_khz} >= lim_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lim_q <= '0;
         run_q <= 1'b0;
         fin   <= 1'b0;
         pdiv  <= PD_W'(1);
      end else if (go) begin
         pdiv  <= PD_W'(1);
         lim_q <= LW'(2 * STEP_KHZ);
         run_q <= 1'b1;
         fin   <= 1'b0;
      end else if (run_q) begin
         if (step_c) begin
            pdiv  <= pdiv + PD_W'(1);
            lim_q <= lim_q + LW'(STEP_KHZ);
         end else begin
            run_q <= 1'b0;
            fin   <= 1'b1;
         end
      end else begin
         fin <= 1'b0;
      end
   end
endmodule

// File: rtl/pllcfg_divider.sv
module pllcfg_divider #(
   parameter int unsigned DW = 64,
   parameter int unsigned VW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [DW-1:0] dividend,
   input  logic [VW-1:0] divisor,
   output logic          fin,
   output logic [DW-1:0] quot
);
   localparam int unsigned CW = $clog2(DW + 1);

   logic [VW-1:0] rem_q;
   logic [VW-1:0] dvs_q;
   logic [CW-1:0] cnt_q;
   logic [VW:0]   trial_c;
   logic [VW:0]   diff_c;
   logic          ge_c;

   // one restoring step per cycle; the quotient shifts in where the dividend shifts out
   always_comb begin
      trial_c = {rem_q, quot[DW-1]};
      ge_c    = trial_c >= {1'b0, dvs_q};
      diff_c  = ge_c ? (trial_c - {1'b0, dvs_q}) : trial_c;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         dvs_q <= '0;
         cnt_q <= '0;
         quot  <= '0;
         fin   <= 1'b0;
      end else if (go) begin
         rem_q <= '0;
         dvs_q <= divisor;
         quot  <= dividend;
         cnt_q <= CW'(DW);
         fin   <= 1'b0;
      end else if (cnt_q != '0) begin
         rem_q <= diff_c[VW-1:0];
         quot  <= {quot[DW-2:0], ge_c};
         cnt_q <= cnt_q - CW'(1);
         fin   <= (cnt_q == CW'(1));
      end else begin
         fin <= 1'b0;
      end
   end
endmodule

// File: rtl/pllcfg_range.sv
module pllcfg_range #(
   parameter int unsigned DW = 64
) (
   input  logic [DW-1:0]                   rate,
   output logic [pllcfg_pkg::RANGE_W-1:0] code
);
   import pllcfg_pkg::*;

   logic [RANGE_N-1:0] hit;

   for (genvar k = 0; k < RANGE_N; k++) begin : g_th
      assign hit[k] = rate >= DW'(RANGE_TH[k]);
   end

   always_comb begin
      code = RANGE_W'($countones(hit));
   end
endmodule

// File: rtl/pll_word_calc.sv
module pll_word_calc #(
   parameter int unsigned W        = 32,
   parameter int unsigned PD_W     = 5,
   parameter int unsigned MUL_W    = 8,
   parameter int unsigned LP_W     = 6,
   parameter int unsigned STEP_KHZ = 5000,
   parameter int unsigned LP_KHZ   = 10000
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               start,
   input  logic [W-1:0]                       target_kbps,
   input  logic [W-1:0]                       ref_khz,
   output logic                               busy,
   output logic                               done,
   output logic [pllcfg_pkg::WORD_W-1:0]      pll_word,
   output logic [W+MUL_W-1:0]                 pll_freq,
   output logic [LP_W-1:0]                    lp_field
);
   import pllcfg_pkg::*;

   localparam int unsigned DW     = 2 * W;
   localparam int unsigned FW     = W + MUL_W;
   localparam int unsigned PAD_W  = WORD_W - RANGE_W - PD_W - MUL_W;
   localparam int unsigned LP_DEN = LP_KHZ * 8;

   if (PD_W + MUL_W + RANGE_W >= WORD_W) begin : g_bad_fields
      $error("pll_word_calc: predivider and multiplier fields do not fit the word");
   end
   if (W < 24 || LP_W < 1 || STEP_KHZ == 0 || LP_KHZ == 0) begin : g_bad_params
      $error("pll_word_calc: parameter out of range");
   end

   calc_st_t            st_q;
   logic [W-1:0]        ref_q, tgt_q;
   logic [PD_W-1:0]     pd_q;
   logic [W-1:0]        mul_q;
   logic [WORD_W-1:0]   word_q;
   logic [FW-1:0]       freq_q;
   logic                srch_go, srch_fin;
   logic [PD_W-1:0]     srch_pd;
   logic                div_go, div_fin;
   logic [DW-1:0]       div_a, div_q, lpm1_c;
   logic [W-1:0]        div_b;
   logic [RANGE_W-1:0]  rng_c;
   logic [MUL_W-1:0]    mf_c;
   logic [PD_W-1:0]     df_c;
   logic [WORD_W-1:0]   word_c;

   pllcfg_presearch #(.W(W), .PD_W(PD_W), .STEP_KHZ(STEP_KHZ)) u_search (
      .clk(clk), .rst_n(rst_n), .go(srch_go), .ref_khz(ref_q),
      .fin(srch_fin), .pdiv(srch_pd)
   );

   pllcfg_divider #(.DW(DW), .VW(W)) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(div_a), .divisor(div_b),
      .fin(div_fin), .quot(div_q)
   );

   pllcfg_range #(.DW(DW)) u_range (
      .rate(div_q), .code(rng_c)
   );

   always_comb begin
      mf_c   = (mul_q[MUL_W-1:0] == '0) ? MUL_W'(1) : mul_q[MUL_W-1:0];
      df_c   = (pd_q == '0) ? PD_W'(1) : pd_q;
      word_c = {rng_c, PAD_W'(0), pd_q, mul_q[MUL_W-1:0]};
      lpm1_c = div_q - DW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         ref_q    <= '0;
         tgt_q    <= '0;
         pd_q     <= '0;
         mul_q    <= '0;
         word_q   <= '0;
         freq_q   <= '0;
         srch_go  <= 1'b0;
         div_go   <= 1'b0;
         div_a    <= '0;
         div_b    <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
         pll_word <= '0;
         pll_freq <= '0;
         lp_field <= '0;
      end else begin
         srch_go <= 1'b0;
         div_go  <= 1'b0;
         done    <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start) begin
               ref_q   <= ref_khz;
               tgt_q   <= target_kbps;
               srch_go <= 1'b1;
               busy    <= 1'b1;
               st_q    <= ST_SEARCH;
            end
            ST_SEARCH: if (srch_fin) begin
               // ceiling quotient as (a + b - 1) / b
               pd_q   <= srch_pd;
               div_a  <= DW'(tgt_q) * DW'(srch_pd) + DW'(ref_q) - DW'(1);
               div_b  <= ref_q;
               div_go <= 1'b1;
               st_q   <= ST_MUL;
            end
            ST_MUL: if (div_fin) begin
               mul_q  <= div_q[W-1:0];
               div_a  <= DW'(ref_q) * DW'(div_q[W-1:0]);
               div_b  <= W'(pd_q);
               div_go <= 1'b1;
               st_q   <= ST_ACH;
            end
            ST_ACH: if (div_fin) begin
               word_q <= word_c;
               div_a  <= DW'(ref_q) * DW'(mf_c);
               div_b  <= W'(df_c);
               div_go <= 1'b1;
               st_q   <= ST_DEC;
            end
            ST_DEC: if (div_fin) begin
               freq_q <= div_q[FW-1:0];
               div_a  <= DW'(div_q[FW-1:0]) + DW'(LP_DEN - 1);
               div_b  <= W'(LP_DEN);
               div_go <= 1'b1;
               st_q   <= ST_LP;
            end
            ST_LP: if (div_fin) begin
               pll_word <= word_q;
               pll_freq <= freq_q;
               lp_field <= lpm1_c[LP_W-1:0];
               done     <= 1'b1;
               busy     <= 1'b0;
               st_q     <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pllcfg_chk.sv
module pllcfg_chk #(
   parameter int unsigned W     = 32,
   parameter int unsigned PD_W  = 5,
   parameter int unsigned MUL_W = 8,
   parameter int unsigned LP_W  = 6
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          start,
   input logic                          busy,
   input logic                          done,
   input logic [pllcfg_pkg::WORD_W-1:0] pll_word,
   input logic [W+MUL_W-1:0]            pll_freq,
   input logic [LP_W-1:0]               lp_field
);
   localparam int unsigned PD_LO = MUL_W;
   localparam int unsigned PD_HI = MUL_W + PD_W - 1;

   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(pll_word) && $stable(pll_freq) && $stable(lp_field)));

   a_r2_pdiv_field: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pll_word[PD_HI:PD_LO] != '0 && pll_word[PD_HI+1] == 1'b0));

   a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind pll_word_calc pllcfg_chk #(.W(W), .PD_W(PD_W), .MUL_W(MUL_W), .LP_W(LP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .pll_word(pll_word), .pll_freq(pll_freq), .lp_field(lp_field)
);

// File: tb/test_pll_word_calc.sv
module test_pll_word_calc;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] target_kbps = '0;
   logic [31:0] ref_khz = '0;
   logic        busy, done;
   logic [15:0] pll_word;
   logic [39:0] pll_freq;
   logic [5:0]  lp_field;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pll_word_calc i_pll_word_calc (
      .clk(clk), .rst_n(rst_n), .start(start), .target_kbps(target_kbps),
      .ref_khz(ref_khz), .busy(busy), .done(done), .pll_word(pll_word),
      .pll_freq(pll_freq), .lp_field(lp_field)
   );

   task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void model(input longint unsigned t, input longint unsigned r,
                                 output logic [15:0] w, output longint unsigned f,
                                 output logic [5:0] lp);
      longint unsigned d, mul, ach, mf, cnt;
      logic [1:0] code;
      d = r / 5000;
      if (d < 1) d = 1;
      if (d > 31) d = 31;
      mul = ((t * d + r - 1) / r) & 64'hFFFF_FFFF;
      ach = (r * mul) / d;
      code = (ach >= 501000) ? 2'd3 : (ach >= 251000) ? 2'd2 : (ach >= 126000) ? 2'd1 : 2'd0;
      w = {code, 1'b0, d[4:0], mul[7:0]};
      mf = (mul[7:0] == 8'd0) ? 1 : {56'd0, mul[7:0]};
      f = (r * mf) / d;
      cnt = (f + 79999) / 80000;
      lp = 6'(cnt - 1);
   endfunction

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (done) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   task automatic run(input longint unsigned t, input longint unsigned r, input bit late_start);
      logic [15:0] ew;
      longint unsigned ef;
      logic [5:0] elp;
      bit ok;
      model(t, r, ew, ef, elp);
      @(negedge clk);
      target_kbps = 32'(t);
      ref_khz = 32'(r);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R8 busy after start", longint'(busy), 1);
      if (late_start) begin
         repeat (5) @(negedge clk);
         target_kbps = 32'(t + 77777);
         ref_khz = 32'(r / 2 + 1);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait_done(ok);
      check("R7 done seen", longint'(ok), 1);
      check("R2 predivider", longint'(pll_word[13:8]), longint'(ew[13:8]));
      check("R3 multiplier", longint'(pll_word[7:0]), longint'(ew[7:0]));
      check("R4 range code", longint'(pll_word[15:14]), longint'(ew[15:14]));
      check("R5 decoded freq", pll_freq, ef);
      check("R6 lp field", longint'(lp_field), longint'(elp));
      @(negedge clk);
      check("R7 single pulse", longint'(done), 0);
      check("R7 word held", longint'(pll_word), longint'(ew));
   endtask

   initial begin
      wait (cycles >= MAX_CYCLES);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=<%0d", cycles, MAX_CYCLES);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   always @(posedge clk) cycles <= cycles + 1;

   initial begin
      void'($urandom(32'd2828));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 busy", longint'(busy), 0);
      check("R1 done", longint'(done), 0);
      check("R1 word", longint'(pll_word), 0);
      check("R1 freq", pll_freq, 0);
      check("R1 lp", longint'(lp_field), 0);
      rst_n = 1'b1;

      // R2 predivider floor / step / clamp
      run(400000, 9999, 1'b0);
      run(400000, 10000, 1'b0);
      run(900000, 200000, 1'b0);
      run(900000, 159999, 1'b0);
      // R4 range boundaries with predivider 1, rate multiple of 1000
      run(126000, 1000, 1'b0);
      run(125000, 1000, 1'b0);
      run(251000, 1000, 1'b0);
      run(250000, 1000, 1'b0);
      run(501000, 1000, 1'b0);
      run(500000, 1000, 1'b0);
      // R5 multiplier of exactly 256: zero field decodes as 1
      run(1280000, 10000, 1'b0);
      // R6 wrap of the 6-bit low-power field
      run(8225000, 1000000, 1'b0);
      // R8 start while busy ignored
      run(600000, 27000, 1'b1);

      for (int n = 0; n < 150; n++) begin
         longint unsigned rr, tt;
         rr = 1000 + longint'($urandom % 200000);
         tt = 50000 + longint'($urandom % 1500000);
         run(tt, rr, (n % 10) == 3);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule